// File: doc/BRIEF.md
# Receive Event Timestamp Capture Bank

This block sits beside a receive parser in a network port that supports precision time synchronisation. On every start-of-frame strobe it decides, from the parsed protocol version, the message type and whether the frame came over UDP, whether the frame is a timing event worth stamping. When it is, the block copies the running 64-bit nanosecond time into the lowest-numbered free slot of a four-slot bank and locks that slot. One cycle later it reports the slot index with a valid strobe, so the index can travel with the frame descriptor to software.

Software reads a slot one 32-bit half at a time, first the low half and then the high half. Reading the high half frees the slot. A status vector shows which slots hold an unread stamp. If every slot is locked, qualifying frames get no stamp until software frees one.

Top module: `rxts_capture_bank`

## Requirements
- R1: After a synchronous active-low reset, `slot_busy` is 4'b0000 and `stamp_vld` is low.
- R2: A qualifying frame (`sof` high) while some slot is free raises `stamp_vld` in the next cycle. `stamp_idx` is the lowest-numbered free slot, and that slot stores the value of `time_ns` sampled on the `sof` edge.
- R3: The slot used for a stamp has its `slot_busy` bit set from the cycle in which `stamp_vld` is high, and the bit stays set until that slot is released.
- R4: A read (`rd_en` high) places a word of slot `rd_slot` on `rd_data` in the next cycle. `rd_hi`=0 selects bits 31:0 and `rd_hi`=1 selects bits 63:32.
- R5: A high-half read clears the `slot_busy` bit of that slot. A low-half read leaves `slot_busy` unchanged.
- R6: While all four slots are busy, a qualifying frame produces no stamp and leaves `slot_busy` unchanged. Stamping resumes once a slot has been freed.
- R7: With `cfg_ver_sel`=1 (version 1), a frame qualifies only if `frm_ver`=1, `frm_udp`=1 and `cfg_udp_en`=1. With `cfg_udp_en`=0, nothing is stamped.
- R8: With `cfg_ver_sel`=2 (version 2), a frame with `frm_ver`=2 carried directly over layer 2 (`frm_udp`=0) qualifies whatever `cfg_udp_en` is. A UDP-carried one (`frm_udp`=1) qualifies only if `cfg_udp_en`=1.
- R9: A frame qualifies only if `frm_msg` equals `cfg_msg`.
- R10: When a high-half read of a slot and a qualifying frame fall in the same cycle, the released slot is not given to that frame. The frame takes the lowest other free slot, or is dropped if there is none, and the read returns the slot's old high half.
- R11: `cfg_ver_sel` values 0 and 3 stamp no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_ns | input | 64 | Running time in nanoseconds |
| sof | input | 1 | Start-of-frame strobe carrying parsed fields |
| frm_ver | input | 4 | Parsed protocol version of the frame |
| frm_msg | input | 4 | Parsed message type of the frame |
| frm_udp | input | 1 | 1 when the frame was carried over UDP |
| cfg_ver_sel | input | 2 | Version to stamp: 1 = v1, 2 = v2, others = none |
| cfg_udp_en | input | 1 | Permits stamping of UDP-carried messages |
| cfg_msg | input | 4 | Message type that is stamped |
| rd_en | input | 1 | Read strobe |
| rd_slot | input | 2 | Slot to read |
| rd_hi | input | 1 | 0 = low half, 1 = high half (frees the slot) |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| slot_busy | output | 4 | Bit n set while slot n holds an unread stamp |
| stamp_vld | output | 1 | A stamp was taken for the frame one cycle earlier |
| stamp_idx | output | 2 | Slot index of that stamp |

## Verification
The hardest case to reach is a release and a capture in the same cycle, with the bank full or nearly full. Only then does it matter that a freed slot is kept away from the incoming frame. The stimulus first fills all four slots. It then raises a high-half read and a qualifying start-of-frame on the same edge twice: once with no other slot free, where the frame must be dropped, and once with another hole open below the released slot, where the frame must land in that hole. The filter cases (version, UDP, message type) come from a vector table, with each stamped slot freed between vectors.

// File: rtl/rxts_pkg.sv
// Shared encodings for the receive timestamp capture bank.
package rxts_pkg;
    // Version select codes; the codes are fixed by the configuration field.
    typedef enum logic [1:0] {
        VSEL_NONE = 2'd0,
        VSEL_V1   = 2'd1,
        VSEL_V2   = 2'd2,
        VSEL_RSVD = 2'd3
    } ver_sel_e;
endpackage

// File: rtl/rxts_qualify.sv
// Frame qualifier: decides whether the frame at a start-of-frame strobe is a
// stampable event. Purely combinational.
// Assumes the parsed fields are valid in the cycle sof is high.
module rxts_qualify
    import rxts_pkg::*;
#(
    parameter int VER_W = 4,
    parameter int MSG_W = 4
) (
    input  logic             sof,
    input  logic [VER_W-1:0] frm_ver,
    input  logic [MSG_W-1:0] frm_msg,
    input  logic             frm_udp,
    input  ver_sel_e         ver_sel,
    input  logic             udp_en,
    input  logic [MSG_W-1:0] msg_sel,
    output logic             hit
);
    logic v1_ok, v2_ok;

    // Version 1 only ever travels over UDP; version 2 may also ride layer 2.
    always_comb begin
        v1_ok = (ver_sel == VSEL_V1) && (frm_ver == VER_W'(1)) && frm_udp && udp_en;
        v2_ok = (ver_sel == VSEL_V2) && (frm_ver == VER_W'(2)) && (!frm_udp || udp_en);
        hit   = sof && (frm_msg == msg_sel) && (v1_ok || v2_ok);
    end
endmodule

// File: rtl/rxts_slot_alloc.sv
// Slot allocator: grants the lowest-numbered slot set in the free mask.
// Assumes the caller has already removed slots being released this cycle.
module rxts_slot_alloc #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     free_mask,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             any_free
);
    // Scan from the top down so the lowest free slot is the last one kept.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any_free  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_mask[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                grant_idx = IDX_W'(i);
                any_free  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxts_slot_bank.sv
// Slot bank: N locked 2-word timestamp slots with a busy bit each, plus the
// registered read port. A write grant locks a slot; a release frees it.
// Assumes grant and release never target the same slot in one cycle.
module rxts_slot_bank #(
    parameter int N      = 4,
    parameter int IDX_W  = 2,
    parameter int TIME_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          wr_grant,
    input  logic [TIME_W-1:0]     time_in,
    input  logic [N-1:0]          release_mask,
    input  logic                  rd_en,
    input  logic [IDX_W-1:0]      rd_slot,
    input  logic                  rd_hi,
    output logic [TIME_W/2-1:0]   rd_data,
    output logic [N-1:0]          busy
);
    localparam int WORD_W = TIME_W / 2;

    logic [TIME_W-1:0] ts_view [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [TIME_W-1:0] ts_q;
        logic              busy_q;

        // Lock the slot on a grant, free it on a release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ts_q   <= '0;
                busy_q <= 1'b0;
            end else if (wr_grant[g]) begin
                ts_q   <= time_in;
                busy_q <= 1'b1;
            end else if (release_mask[g]) begin
                busy_q <= 1'b0;
            end
        end

        assign ts_view[g] = ts_q;
        assign busy[g]    = busy_q;
    end

    // Register the requested half of the addressed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_hi ? ts_view[rd_slot][WORD_W +: WORD_W]
                             : ts_view[rd_slot][0 +: WORD_W];
        end
    end

    // R5: a high-half read frees the addressed slot.
    a_r5_hi_read_frees : assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_hi) |=> !busy[$past(rd_slot)]);

    // R5: a low-half read keeps a busy slot locked.
    a_r5_lo_read_keeps : assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hi && busy[rd_slot]) |=> busy[$past(rd_slot)]);
endmodule

// File: rtl/rxts_capture_bank.sv
// Receive timestamp capture bank (top). Qualifies frames, picks the lowest
// free slot (excluding one being released by a high-half read this cycle),
// latches the time there, and reports the slot index one cycle after sof.
// Assumes time_ns is stable around the clock edge that samples sof.
module rxts_capture_bank
    import rxts_pkg::*;
#(
    parameter int N      = 4,
    parameter int TIME_W = 64,
    parameter int VER_W  = 4,
    parameter int MSG_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TIME_W-1:0]         time_ns,
    input  logic                      sof,
    input  logic [VER_W-1:0]          frm_ver,
    input  logic [MSG_W-1:0]          frm_msg,
    input  logic                      frm_udp,
    input  logic [1:0]                cfg_ver_sel,
    input  logic                      cfg_udp_en,
    input  logic [MSG_W-1:0]          cfg_msg,
    input  logic                      rd_en,
    input  logic [$clog2(N)-1:0]      rd_slot,
    input  logic                      rd_hi,
    output logic [TIME_W/2-1:0]       rd_data,
    output logic [N-1:0]              slot_busy,
    output logic                      stamp_vld,
    output logic [$clog2(N)-1:0]      stamp_idx
);
    localparam int IDX_W = $clog2(N);

    logic             hit;
    logic [N-1:0]     rel_mask, free_mask, alloc_grant, wr_grant;
    logic [IDX_W-1:0] alloc_idx;
    logic             any_free;

    rxts_qualify #(.VER_W(VER_W), .MSG_W(MSG_W)) u_qual (
        .sof     (sof),
        .frm_ver (frm_ver),
        .frm_msg (frm_msg),
        .frm_udp (frm_udp),
        .ver_sel (ver_sel_e'(cfg_ver_sel)),
        .udp_en  (cfg_udp_en),
        .msg_sel (cfg_msg),
        .hit     (hit)
    );

    // Decode the slot a high-half read releases this cycle.
    always_comb begin
        rel_mask = '0;
        for (int i = 0; i < N; i++) begin
            rel_mask[i] = rd_en && rd_hi && (rd_slot == IDX_W'(i));
        end
    end

    // A releasing slot is not offered to a capture in the same cycle.
    assign free_mask = ~slot_busy & ~rel_mask;

    rxts_slot_alloc #(.N(N), .IDX_W(IDX_W)) u_alloc (
        .free_mask (free_mask),
        .grant     (alloc_grant),
        .grant_idx (alloc_idx),
        .any_free  (any_free)
    );

    assign wr_grant = hit ? alloc_grant : '0;

    rxts_slot_bank #(.N(N), .IDX_W(IDX_W), .TIME_W(TIME_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_grant     (wr_grant),
        .time_in      (time_ns),
        .release_mask (rel_mask),
        .rd_en        (rd_en),
        .rd_slot      (rd_slot),
        .rd_hi        (rd_hi),
        .rd_data      (rd_data),
        .busy         (slot_busy)
    );

    // Report the granted slot one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_vld <= 1'b0;
            stamp_idx <= '0;
        end else begin
            stamp_vld <= hit && any_free;
            stamp_idx <= alloc_idx;
        end
    end

    // R3: a reported slot is locked.
    a_r3_stamp_slot_busy : assert property (@(posedge clk) disable iff (!rst_n)
        stamp_vld |-> slot_busy[stamp_idx]);

    // R6: a full bank takes no stamp.
    a_r6_full_no_stamp : assert property (@(posedge clk) disable iff (!rst_n)
        (sof && (&slot_busy)) |=> !stamp_vld);

    // R10: a slot released this cycle is never reused by the same capture.
    a_r10_release_not_reused : assert property (@(posedge clk) disable iff (!rst_n)
        (sof && rd_en && rd_hi) |=> !(stamp_vld && (stamp_idx == $past(rd_slot))));

    // R2: at most one slot is granted.
    a_r2_single_grant : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_grant));
endmodule

// File: tb/sim_rxts_capture_bank.sv
module sim_rxts_capture_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_ns = '0;
    logic        sof = 1'b0;
    logic [3:0]  frm_ver = '0, frm_msg = '0, cfg_msg = '0;
    logic        frm_udp = 1'b0, cfg_udp_en = 1'b0;
    logic [1:0]  cfg_ver_sel = '0;
    logic        rd_en = 1'b0, rd_hi = 1'b0;
    logic [1:0]  rd_slot = '0;
    logic [31:0] rd_data;
    logic [3:0]  slot_busy;
    logic        stamp_vld;
    logic [1:0]  stamp_idx;

    int n_chk = 0, n_bad = 0;
    logic [63:0] exp_ts [4];

    always #4 clk = ~clk;

    rxts_capture_bank u0 (
        .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .sof(sof),
        .frm_ver(frm_ver), .frm_msg(frm_msg), .frm_udp(frm_udp),
        .cfg_ver_sel(cfg_ver_sel), .cfg_udp_en(cfg_udp_en), .cfg_msg(cfg_msg),
        .rd_en(rd_en), .rd_slot(rd_slot), .rd_hi(rd_hi), .rd_data(rd_data),
        .slot_busy(slot_busy), .stamp_vld(stamp_vld), .stamp_idx(stamp_idx)
    );

    // Fields: {ver_sel[2], udp_en, cfg_msg[4], f_ver[4], f_msg[4], f_udp, expect}
    localparam logic [16:0] VEC [12] = '{
        {2'd1, 1'b1, 4'h0, 4'h1, 4'h0, 1'b1, 1'b1},
        {2'd1, 1'b0, 4'h0, 4'h1, 4'h0, 1'b1, 1'b0},
        {2'd1, 1'b1, 4'h0, 4'h1, 4'h0, 1'b0, 1'b0},
        {2'd1, 1'b1, 4'h0, 4'h2, 4'h0, 1'b1, 1'b0},
        {2'd2, 1'b0, 4'h0, 4'h2, 4'h0, 1'b0, 1'b1},
        {2'd2, 1'b0, 4'h0, 4'h2, 4'h0, 1'b1, 1'b0},
        {2'd2, 1'b1, 4'h0, 4'h2, 4'h0, 1'b1, 1'b1},
        {2'd2, 1'b1, 4'h0, 4'h1, 4'h0, 1'b1, 1'b0},
        {2'd2, 1'b1, 4'h0, 4'h2, 4'h1, 1'b0, 1'b0},
        {2'd1, 1'b1, 4'h3, 4'h1, 4'h3, 1'b1, 1'b1},
        {2'd0, 1'b1, 4'h0, 4'h1, 4'h0, 1'b1, 1'b0},
        {2'd3, 1'b1, 4'h0, 4'h2, 4'h0, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one frame; on return stamp_vld/stamp_idx are observable.
    task automatic frame(input logic [3:0] v, input logic [3:0] m, input logic u,
                         input logic [63:0] t);
        @(negedge clk);
        sof = 1'b1; frm_ver = v; frm_msg = m; frm_udp = u; time_ns = t;
        @(negedge clk);
        sof = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, input logic hi);
        @(negedge clk);
        rd_en = 1'b1; rd_slot = s; rd_hi = hi;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Capture and high-half read on the same edge.
    task automatic clash(input logic [1:0] s, input logic [63:0] t);
        @(negedge clk);
        sof = 1'b1; frm_ver = 4'h2; frm_msg = 4'h0; frm_udp = 1'b1; time_ns = t;
        rd_en = 1'b1; rd_slot = s; rd_hi = 1'b1;
        @(negedge clk);
        sof = 1'b0; rd_en = 1'b0;
    endtask

    function automatic string vec_req(input int i);
        if (i < 4) return "R7";
        if (i < 8) return "R8";
        if (i < 10) return "R9";
        return "R11";
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(slot_busy == 4'b0000, "R1 busy", 64'(slot_busy), 64'h0);
        check(stamp_vld == 1'b0, "R1 stamp_vld", 64'(stamp_vld), 64'h0);
        rst_n = 1'b1;

        // Filter table (R7, R8, R9, R11)
        for (int i = 0; i < 12; i++) begin
            logic [63:0] t;
            t = {32'hC000_0000 + 32'(i), 32'h0000_5000 + 32'(i)};
            @(negedge clk);
            cfg_ver_sel = VEC[i][16:15]; cfg_udp_en = VEC[i][14];
            cfg_msg = VEC[i][13:10];
            frame(VEC[i][9:6], VEC[i][5:2], VEC[i][1], t);
            check(stamp_vld == VEC[i][0], vec_req(i), 64'(stamp_vld), 64'(VEC[i][0]));
            if (VEC[i][0]) begin
                check(stamp_idx == 2'd0, "R2 idx", 64'(stamp_idx), 64'h0);
                rd(2'd0, 1'b1);
                check(rd_data == t[63:32], "R4 high", 64'(rd_data), 64'(t[63:32]));
            end
            check(slot_busy == 4'b0000, "R5 empty after vector", 64'(slot_busy), 64'h0);
        end

        // Fill all slots (R2, R3)
        cfg_ver_sel = 2'd2; cfg_udp_en = 1'b1; cfg_msg = 4'h0;
        for (int s = 0; s < 4; s++) begin
            exp_ts[s] = {32'hA000_0000 + 32'(s), 32'h1000_0000 + 32'(s * 16)};
            frame(4'h2, 4'h0, 1'b1, exp_ts[s]);
            check(stamp_vld && stamp_idx == 2'(s), "R2 fill idx", 64'(stamp_idx), 64'(s));
            check(slot_busy[s], "R3 busy set", 64'(slot_busy), 64'(s));
        end

        // Low read of slot 2 returns low word and keeps busy (R4, R5)
        rd(2'd2, 1'b0);
        check(rd_data == exp_ts[2][31:0], "R4 low", 64'(rd_data), 64'(exp_ts[2][31:0]));
        check(slot_busy == 4'b1111, "R5 low read keeps", 64'(slot_busy), 64'hF);

        // Full bank drops frame (R6)
        frame(4'h2, 4'h0, 1'b1, 64'hDEAD_BEEF_0000_0001);
        check(stamp_vld == 1'b0, "R6 full drop", 64'(stamp_vld), 64'h0);
        check(slot_busy == 4'b1111, "R6 busy unchanged", 64'(slot_busy), 64'hF);

        // High read frees slot 1 (R4, R5), then stamping resumes (R6, R2)
        rd(2'd1, 1'b1);
        check(rd_data == exp_ts[1][63:32], "R4 high", 64'(rd_data), 64'(exp_ts[1][63:32]));
        check(slot_busy == 4'b1101, "R5 high read frees", 64'(slot_busy), 64'hD);
        exp_ts[1] = 64'h1111_2222_3333_4444;
        frame(4'h2, 4'h0, 1'b1, exp_ts[1]);
        check(stamp_vld && stamp_idx == 2'd1, "R6 resume idx", 64'(stamp_idx), 64'h1);
        check(slot_busy == 4'b1111, "R3 busy refilled", 64'(slot_busy), 64'hF);

        // Clash on full bank: release slot 0, capture dropped (R10)
        clash(2'd0, 64'h5555_0000_0000_0000);
        check(stamp_vld == 1'b0, "R10 drop on clash", 64'(stamp_vld), 64'h0);
        check(rd_data == exp_ts[0][63:32], "R10 old high", 64'(rd_data), 64'(exp_ts[0][63:32]));
        check(slot_busy == 4'b1110, "R10 busy", 64'(slot_busy), 64'hE);

        // Open slot 2, then clash on slot 1: capture goes to slot 0 (R10, R2)
        rd(2'd2, 1'b1);
        check(slot_busy == 4'b1010, "R5 free slot 2", 64'(slot_busy), 64'hA);
        exp_ts[0] = 64'h7777_8888_9999_AAAA;
        clash(2'd1, exp_ts[0]);
        check(stamp_vld && stamp_idx == 2'd0, "R10 other slot", 64'(stamp_idx), 64'h0);
        check(rd_data == exp_ts[1][63:32], "R10 old high", 64'(rd_data), 64'(exp_ts[1][63:32]));
        check(slot_busy == 4'b1001, "R10 busy", 64'(slot_busy), 64'h9);
        rd(2'd0, 1'b0);
        check(rd_data == exp_ts[0][31:0], "R2 stored time", 64'(rd_data), 64'(exp_ts[0][31:0]));

        // Reset clears everything (R1)
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(slot_busy == 4'b0000, "R1 re-reset busy", 64'(slot_busy), 64'h0);
        check(stamp_vld == 1'b0, "R1 re-reset vld", 64'(stamp_vld), 64'h0);
        summary();
    end
endmodule